// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a window of 32-bit control and status words addressed by a word offset. A protection latch guards every ordinary write. The bank comes out of reset protected. Software opens it by writing a 16-bit open key to a dedicated offset, and closes it by writing a different 16-bit close key to another offset.

Each mapped offset has one access class: read-write, read-only or write-only. A write that is refused, for any reason, leaves all state unchanged. Such a write, and any read that breaks its offset's class, raises the error output for the same cycle as the request. A read always returns the value held at the offset, even when the read is flagged. Read data appears one cycle after the request.

Bit 0 of one control word requests a soft reset of the system. The block drives that request as a single-cycle pulse.

The interface is plain: the port takes one request per cycle and never stalls, so there is no back-pressure. Both enables may be high in the same cycle. A read in the same cycle as a write returns the value held before that write.

Map (word offsets):

| Offset | Class | Content |
|---|---|---|
| 0x000 | read-write | single-bit control; only bit 0 is kept |
| 0x001 | write-only | close key (0x767B) |
| 0x002 | write-only | open key (0xDF0D) |
| 0x003 | read-only | protection state in bit 0 (1 = protected) |
| 0x040 to 0x04F | read-write | general control words |
| 0x080 | read-write | soft-reset control; bit 0 requests the reset |
| 0x081 to 0x085 | read-only | ID code, boot setting, clock-generator status, two memory-controller status words |
| 0x090, 0x091 | write-only | two command words |

Top module: `keybank_top`

## Requirements
- R1: After reset, the bank is protected (offset 0x003 reads 1), and err and srst_req are low. Offset 0x000 reads 0, offset 0x080 reads 0, and the command words read 0. General word k (offset 0x040+k) reads (k+1)*0x00010100.
- R2: A write to 0x001 whose low 16 bits are 0x767B sets protection. A write to 0x002 whose low 16 bits are 0xDF0D clears it. The upper 16 bits are ignored. A wrong key leaves the protection state unchanged and raises no error.
- R3: Writes to 0x001 and 0x002 are accepted in either protection state and never raise err.
- R4: While protected, a write to any other offset is discarded and err is high in the same cycle.
- R5: A write to an unmapped or read-only offset is discarded and raises err in either protection state.
- R6: A read of an unmapped or write-only offset raises err in the same cycle. The command words still return their stored value. The key offsets and unmapped offsets read 0.
- R7: rdata shows the read value from the cycle after rd_en and holds it until the next read.
- R8: A write to 0x000 stores only bit 0 of the data; the other bits read 0.
- R9: An accepted write to 0x080 with bit 0 set drives srst_req high for exactly the following cycle. A refused write to 0x080 gives no pulse.
- R10: The read-only words hold their parameter values: 0x081 ID_CODE, 0x082 BOOT_CFG, 0x083 PLL_STAT, 0x084 DDR_STAT0, 0x085 DDR_STAT1.
- R11: err stays low for every access that is legal for its offset and protection state, and whenever neither enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| ofs | input | ADDR_W | word offset of the request |
| wr_en | input | 1 | write request |
| rd_en | input | 1 | read request |
| wdata | input | DATA_W | write data |
| rdata | output | DATA_W | registered read data |
| err | output | 1 | access violation, same cycle as the request |
| srst_req | output | 1 | one-cycle soft-reset request |

## Verification
The bench builds the block with its default parameters: a 10-bit offset, 32-bit data and 16 general words. With these values the whole 1024-word window can be swept. Every offset is read and written in both protection states, so each access class is checked at each offset, including every unmapped hole. Expected read values are derived from the reset formula and a bench-side shadow of the accepted writes. Key handling, wrong keys with noisy upper bits and the soft-reset pulse are then checked one by one.

// File: rtl/keybank_pkg.sv
package keybank_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RW   = 2'd1,
    ACC_RO   = 2'd2,
    ACC_WO   = 2'd3
  } acc_t;

  typedef enum logic [2:0] {
    ROLE_NONE  = 3'd0,
    ROLE_STORE = 3'd1,
    ROLE_BIT0  = 3'd2,
    ROLE_CLOSE = 3'd3,
    ROLE_OPEN  = 3'd4,
    ROLE_STATE = 3'd5,
    ROLE_SRST  = 3'd6,
    ROLE_CONST = 3'd7
  } role_t;

  // word offsets of the fixed map
  localparam int OFS_BIT0   = 'h000;
  localparam int OFS_CLOSE  = 'h001;
  localparam int OFS_OPEN   = 'h002;
  localparam int OFS_STATE  = 'h003;
  localparam int OFS_SRST   = 'h080;
  localparam int OFS_ID     = 'h081;
  localparam int OFS_BOOT   = 'h082;
  localparam int OFS_PLLST  = 'h083;
  localparam int OFS_DDRST0 = 'h084;
  localparam int OFS_DDRST1 = 'h085;
  localparam int OFS_CMD0   = 'h090;
  localparam int OFS_CMD1   = 'h091;

  localparam logic [15:0] CLOSE_KEY = 16'h767B;
  localparam logic [15:0] OPEN_KEY  = 16'hDF0D;

  // storage slot numbering
  localparam int SLOT_BIT0 = 0;
  localparam int SLOT_SRST = 1;
  localparam int SLOT_CMD0 = 2;
  localparam int SLOT_CMD1 = 3;
  localparam int SLOT_GP0  = 4;

  // constant word indices carried in the slot field
  localparam int K_ID    = 0;
  localparam int K_BOOT  = 1;
  localparam int K_PLL   = 2;
  localparam int K_DDR0  = 3;
  localparam int K_DDR1  = 4;

endpackage

// File: rtl/keybank_decode.sv
module keybank_decode #(
  parameter int ADDR_W  = 10,
  parameter int GP_BASE = 'h040,
  parameter int GP_N    = 16,
  parameter int SLOT_W  = 5
) (
  input  logic [ADDR_W-1:0]       ofs,
  output keybank_pkg::acc_t       acc,
  output keybank_pkg::role_t      role,
  output logic [SLOT_W-1:0]       slot
);
  import keybank_pkg::*;

  logic [ADDR_W-1:0] rel;

  always_comb begin
    acc  = ACC_NONE;
    role = ROLE_NONE;
    slot = '0;
    rel  = ofs - ADDR_W'(GP_BASE);
    case (ofs)
      ADDR_W'(OFS_BIT0):   begin acc = ACC_RW; role = ROLE_BIT0;  slot = SLOT_W'(SLOT_BIT0); end
      ADDR_W'(OFS_CLOSE):  begin acc = ACC_WO; role = ROLE_CLOSE; end
      ADDR_W'(OFS_OPEN):   begin acc = ACC_WO; role = ROLE_OPEN;  end
      ADDR_W'(OFS_STATE):  begin acc = ACC_RO; role = ROLE_STATE; end
      ADDR_W'(OFS_SRST):   begin acc = ACC_RW; role = ROLE_SRST;  slot = SLOT_W'(SLOT_SRST); end
      ADDR_W'(OFS_ID):     begin acc = ACC_RO; role = ROLE_CONST; slot = SLOT_W'(K_ID);   end
      ADDR_W'(OFS_BOOT):   begin acc = ACC_RO; role = ROLE_CONST; slot = SLOT_W'(K_BOOT); end
      ADDR_W'(OFS_PLLST):  begin acc = ACC_RO; role = ROLE_CONST; slot = SLOT_W'(K_PLL);  end
      ADDR_W'(OFS_DDRST0): begin acc = ACC_RO; role = ROLE_CONST; slot = SLOT_W'(K_DDR0); end
      ADDR_W'(OFS_DDRST1): begin acc = ACC_RO; role = ROLE_CONST; slot = SLOT_W'(K_DDR1); end
      ADDR_W'(OFS_CMD0):   begin acc = ACC_WO; role = ROLE_STORE; slot = SLOT_W'(SLOT_CMD0); end
      ADDR_W'(OFS_CMD1):   begin acc = ACC_WO; role = ROLE_STORE; slot = SLOT_W'(SLOT_CMD1); end
      default: begin
        if (ofs >= ADDR_W'(GP_BASE) && rel < ADDR_W'(GP_N)) begin
          acc  = ACC_RW;
          role = ROLE_STORE;
          slot = SLOT_W'(rel) + SLOT_W'(SLOT_GP0);
        end
      end
    endcase
  end

endmodule

// File: rtl/keybank_lock.sv
module keybank_lock #(
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_wr,
  input  logic             open_wr,
  input  logic [KEY_W-1:0] key,
  output logic             locked
);
  import keybank_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b1;
    end else if (close_wr && key == KEY_W'(CLOSE_KEY)) begin
      locked <= 1'b1;
    end else if (open_wr && key == KEY_W'(OPEN_KEY)) begin
      locked <= 1'b0;
    end
  end

endmodule

// File: rtl/keybank_store.sv
module keybank_store #(
  parameter int DATA_W      = 32,
  parameter int NSLOT       = 20,
  parameter int SLOT_W      = 5,
  parameter int GP_RST_STEP = 'h00010100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [DATA_W-1:0] wval,
  input  logic [SLOT_W-1:0] rslot,
  output logic [DATA_W-1:0] rval
);
  import keybank_pkg::*;

  logic [NSLOT*DATA_W-1:0] flat;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [DATA_W-1:0] RV =
      (i >= SLOT_GP0) ? DATA_W'((i - SLOT_GP0 + 1) * GP_RST_STEP) : '0;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= RV;
      end else if (we && wslot == SLOT_W'(i)) begin
        q <= wval;
      end
    end
    assign flat[i*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rval = '0;
    if (int'(rslot) < NSLOT) begin
      rval = flat[int'(rslot)*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/keybank_top.sv
module keybank_top #(
  parameter int          ADDR_W    = 10,
  parameter int          DATA_W    = 32,
  parameter int          GP_BASE   = 'h040,
  parameter int          GP_N      = 16,
  parameter logic [31:0] ID_CODE   = 32'h1B0C_5A01,
  parameter logic [31:0] BOOT_CFG  = 32'h0000_0005,
  parameter logic [31:0] PLL_STAT  = 32'h0000_003F,
  parameter logic [31:0] DDR_STAT0 = 32'h0000_0011,
  parameter logic [31:0] DDR_STAT1 = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ofs,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              srst_req
);
  import keybank_pkg::*;

  localparam int NSLOT  = SLOT_GP0 + GP_N;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int KEY_W  = 16;

  acc_t              acc;
  role_t             role;
  logic [SLOT_W-1:0] slot;
  logic              lock_q;
  logic              wr_class_ok, rd_class_ok;
  logic              key_wr, commit;
  logic [DATA_W-1:0] wval, sval, rnext, kval;

  keybank_decode #(
    .ADDR_W(ADDR_W), .GP_BASE(GP_BASE), .GP_N(GP_N), .SLOT_W(SLOT_W)
  ) u_dec (
    .ofs(ofs), .acc(acc), .role(role), .slot(slot)
  );

  assign wr_class_ok = (acc == ACC_RW) || (acc == ACC_WO);
  assign rd_class_ok = (acc == ACC_RW) || (acc == ACC_RO);
  assign key_wr      = wr_en && (role == ROLE_CLOSE || role == ROLE_OPEN);
  assign commit      = wr_en && wr_class_ok && !key_wr && !lock_q;

  keybank_lock #(.KEY_W(KEY_W)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .close_wr(key_wr && role == ROLE_CLOSE),
    .open_wr(key_wr && role == ROLE_OPEN),
    .key(wdata[KEY_W-1:0]),
    .locked(lock_q)
  );

  assign wval = (role == ROLE_BIT0) ? {{(DATA_W-1){1'b0}}, wdata[0]} : wdata;

  keybank_store #(
    .DATA_W(DATA_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(commit), .wslot(slot), .wval(wval),
    .rslot(slot), .rval(sval)
  );

  always_comb begin
    case (int'(slot))
      K_ID:    kval = DATA_W'(ID_CODE);
      K_BOOT:  kval = DATA_W'(BOOT_CFG);
      K_PLL:   kval = DATA_W'(PLL_STAT);
      K_DDR0:  kval = DATA_W'(DDR_STAT0);
      K_DDR1:  kval = DATA_W'(DDR_STAT1);
      default: kval = '0;
    endcase
  end

  always_comb begin
    case (role)
      ROLE_STORE, ROLE_BIT0, ROLE_SRST: rnext = sval;
      ROLE_STATE: rnext = {{(DATA_W-1){1'b0}}, lock_q};
      ROLE_CONST: rnext = kval;
      default:    rnext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      srst_req <= 1'b0;
    end else begin
      if (rd_en) rdata <= rnext;
      srst_req <= commit && (role == ROLE_SRST) && wdata[0];
    end
  end

  assign err = (wr_en && !key_wr && !commit) || (rd_en && !rd_class_ok);

endmodule

// File: rtl/keybank_chk.sv
module keybank_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ofs,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wdata,
  input logic              err,
  input logic              srst_req,
  input logic              locked
);
  import keybank_pkg::*;

  logic is_close, is_open;
  assign is_close = (ofs == ADDR_W'(OFS_CLOSE));
  assign is_open  = (ofs == ADDR_W'(OFS_OPEN));

  assert_close_key_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_close && wdata[15:0] == CLOSE_KEY) |=> locked);

  assert_open_key_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_open && wdata[15:0] == OPEN_KEY) |=> !locked);

  assert_state_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(locked));

  assert_protected_write_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && !is_close && !is_open) |-> err);

  assert_key_write_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && (is_close || is_open)) |-> !err);

  assert_wo_read_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (ofs == ADDR_W'(OFS_CMD0) || ofs == ADDR_W'(OFS_CMD1))) |-> err);

  assert_srst_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |-> $past(wr_en && !locked && ofs == ADDR_W'(OFS_SRST) && wdata[0]));

  assert_err_needs_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (wr_en || rd_en));

endmodule

bind keybank_top keybank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ofs(ofs), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .err(err), .srst_req(srst_req), .locked(lock_q)
);

// File: tb/sim_keybank_top.sv
module sim_keybank_top;

  localparam int AW = 10;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ofs = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          err;
  logic          srst_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] model [NW];
  bit          prot;

  always #4 clk = ~clk;

  keybank_top u0 (
    .clk(clk), .rst_n(rst_n), .ofs(ofs), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .err(err), .srst_req(srst_req)
  );

  // 0 none, 1 rw, 2 ro, 3 wo
  function automatic int cls(int o);
    if (o == 'h000 || o == 'h080) return 1;
    if (o == 'h001 || o == 'h002 || o == 'h090 || o == 'h091) return 3;
    if (o == 'h003 || (o >= 'h081 && o <= 'h085)) return 2;
    if (o >= 'h040 && o <= 'h04F) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] pat(int o);
    return 32'h3C00_0000 ^ (o * 32'h0001_0003) ^ 32'h0000_8001;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_rd(int o, output logic [31:0] d, output logic e);
    @(negedge clk);
    ofs = AW'(o); rd_en = 1'b1;
    #1 e = err;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_wr(int o, logic [31:0] v, output logic e);
    @(negedge clk);
    ofs = AW'(o); wdata = v; wr_en = 1'b1;
    #1 e = err;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    for (int i = 0; i < NW; i++) model[i] = '0;
    for (int k = 0; k < 16; k++) model['h040 + k] = (k + 1) * 32'h0001_0100;
    model['h003] = 32'd1;
    model['h081] = 32'h1B0C_5A01;
    model['h082] = 32'h0000_0005;
    model['h083] = 32'h0000_003F;
    model['h084] = 32'h0000_0011;
    model['h085] = 32'h0000_0000;
    prot = 1'b1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 err after reset", {31'b0, err}, 32'd0);
    chk("R1 srst_req after reset", {31'b0, srst_req}, 32'd0);

    // R1 R6 R10: full read sweep of reset state
    for (int o = 0; o < NW; o++) begin
      do_rd(o, d, e);
      chk("R1 R10 reset read value", d, model[o]);
      chk("R6 R11 read flag", {31'b0, e},
          {31'b0, (cls(o) == 0 || cls(o) == 3)});
    end

    // R4 R5: protected write sweep, nothing may change
    for (int o = 0; o < NW; o++) begin
      if (o == 'h001 || o == 'h002) continue;
      do_wr(o, pat(o), e);
      chk("R4 R5 protected write flag", {31'b0, e}, 32'd1);
    end
    for (int o = 0; o < NW; o++) begin
      do_rd(o, d, e);
      chk("R4 protected write discarded", d, model[o]);
    end

    // R2 R3: open with noisy upper bits
    do_wr('h002, 32'hFFFF_DF0D, e);
    chk("R3 open key no flag", {31'b0, e}, 32'd0);
    prot = 1'b0; model['h003] = 32'd0;
    do_rd('h003, d, e);
    chk("R2 open key clears state", d, 32'd0);

    // R5 R8 R11: open write sweep (soft-reset word handled apart)
    for (int o = 0; o < NW; o++) begin
      if (o == 'h001 || o == 'h002 || o == 'h080) continue;
      do_wr(o, pat(o), e);
      chk("R5 R11 open write flag", {31'b0, e},
          {31'b0, (cls(o) == 0 || cls(o) == 2)});
      if (cls(o) == 1 || cls(o) == 3)
        model[o] = (o == 'h000) ? {31'b0, pat(o)[0]} : pat(o);
    end
    for (int o = 0; o < NW; o++) begin
      do_rd(o, d, e);
      chk("R6 R8 open readback", d, model[o]);
    end

    // R9: soft-reset pulse
    do_wr('h080, 32'h0000_0003, e);
    chk("R9 srst_req pulse", {31'b0, srst_req}, 32'd1);
    @(negedge clk);
    chk("R9 srst_req one cycle", {31'b0, srst_req}, 32'd0);
    do_rd('h080, d, e);
    chk("R9 srst word stored", d, 32'h0000_0003);
    do_wr('h080, 32'h0000_0002, e);
    chk("R9 no pulse with bit0 clear", {31'b0, srst_req}, 32'd0);

    // R7: read data held while idle
    do_rd('h041, d, e);
    repeat (3) @(negedge clk);
    chk("R7 rdata held", rdata, model['h041]);

    // R2: wrong key changes nothing
    do_wr('h001, 32'h0000_767C, e);
    chk("R2 wrong key no flag", {31'b0, e}, 32'd0);
    do_rd('h003, d, e);
    chk("R2 wrong key state kept", d, 32'd0);
    do_wr('h002, 32'h0000_767B, e);
    do_rd('h003, d, e);
    chk("R2 close key at open offset ignored", d, 32'd0);

    // R2: close with noisy upper bits
    do_wr('h001, 32'hABCD_767B, e);
    chk("R3 close key no flag", {31'b0, e}, 32'd0);
    do_rd('h003, d, e);
    chk("R2 close key sets state", d, 32'd1);

    // R9 R4: refused soft-reset write
    do_wr('h080, 32'h0000_0001, e);
    chk("R4 protected srst write flag", {31'b0, e}, 32'd1);
    chk("R9 no pulse while protected", {31'b0, srst_req}, 32'd0);
    do_rd('h080, d, e);
    chk("R9 srst word unchanged", d, 32'h0000_0002);

    // R3: close again while already protected, then open while protected
    do_wr('h001, 32'h0000_767B, e);
    chk("R3 close while protected no flag", {31'b0, e}, 32'd0);
    do_wr('h002, 32'h0000_DF0D, e);
    do_rd('h003, d, e);
    chk("R3 open accepted while protected", d, 32'd0);

    // R11: idle cycle has no flag
    @(negedge clk);
    chk("R11 idle no flag", {31'b0, err}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule